// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Read-During-Write

A synchronous two-port memory in which each port has its own enable, write enable, address, write data and registered read data. Both ports share one clock and one storage array. A port that is enabled reads the addressed word every cycle, and the word appears on its read output one clock edge later. When write enable is also set, the port stores its write data in the same cycle.

Two kinds of address collision are resolved by parameters instead of by coding style. The first is a port reading the word it writes in the same cycle. The second is a port reading a word that the other port writes in that cycle. The same-port choice is new data, old data or don't care. The cross-port choice is old data or don't care. In this block, don't care is a defined fill of all ones, so that any leak of it into a defined mode can be seen. Mode codes are 0 for new data, 1 for old data and 2 for don't care.

Top module: `dpram_rdw`

## Requirements
- R1: While `rst` is high at a rising edge, both read outputs become zero and neither port changes the array. Stored words survive a reset.
- R2: A port with enable high and write enable low shows the word stored at its address on its read output after the next rising edge.
- R3: A port with enable low keeps its read output unchanged and does not write, even when its write enable is high.
- R4: A port with enable and write enable high stores its write data at its address, and a later read of that address returns it.
- R5: With SAME_MODE = 0 (new data), a port that writes reads back the data it is writing, one edge later.
- R6: With SAME_MODE = 1 (old data), a port that writes reads back the word held before that write, and the array still takes the new word.
- R7: With SAME_MODE = 2 (don't care), a port that writes returns all ones on its read output.
- R8: With CROSS_MODE = 1 (old data), a port that only reads an address the other port writes in the same cycle returns the word held before that write.
- R9: With CROSS_MODE = 2 (don't care), a port that only reads an address the other port writes in the same cycle returns all ones.
- R10: When both ports write one address in the same cycle, the array keeps port A's data.
- R11: With the default parameters, both collision kinds use don't care (code 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable, effective only with en_a |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | DATA_W | Port A write data |
| rdata_a | output | DATA_W | Port A registered read data |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable, effective only with en_b |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | DATA_W | Port B write data |
| rdata_b | output | DATA_W | Port B registered read data |

## Verification
The assertions assume that all inputs hold known values at each rising edge and that the mode parameters carry one of the listed codes. The defined-mode checks and the all-ones checks need no model of the array, because the expected word comes from the write data or from the fill. The bench therefore keeps every input at a known level from time zero and writes every address before reading it, so no unset word reaches a read output. It runs three copies of the block side by side, together covering every mode code, and drives all three with the same stimulus.

// File: rtl/dpram_rdw_pkg.sv
package dpram_rdw_pkg;
  // collision resolution codes
  localparam logic [1:0] RDW_NEW      = 2'd0;
  localparam logic [1:0] RDW_OLD      = 2'd1;
  localparam logic [1:0] RDW_DONTCARE = 2'd2;
endpackage

// File: rtl/dpram_rdw_array.sv
module dpram_rdw_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] waddr_a,
  input  logic [DATA_W-1:0] wword_a,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] waddr_b,
  input  logic [DATA_W-1:0] wword_b,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rword_a,
  output logic [DATA_W-1:0] rword_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // B is written first so that A takes the word when both hit one address
  always_ff @(posedge clk) begin
    if (wr_b) store[waddr_b] <= wword_b;
    if (wr_a) store[waddr_a] <= wword_a;
  end

  // contents before this edge's writes; the port registers sample them
  assign rword_a = store[raddr_a];
  assign rword_b = store[raddr_b];
endmodule

// File: rtl/dpram_rdw_port.sv
module dpram_rdw_port
  import dpram_rdw_pkg::*;
#(
  parameter int         DATA_W     = 16,
  parameter int         ADDR_W     = 6,
  parameter logic [1:0] SAME_MODE  = RDW_DONTCARE,
  parameter logic [1:0] CROSS_MODE = RDW_DONTCARE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              peer_wr,
  input  logic [ADDR_W-1:0] peer_addr,
  input  logic [DATA_W-1:0] stored,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] same_word;
  logic [DATA_W-1:0] cross_word;
  logic [DATA_W-1:0] next_word;
  logic              cross_hit;

  // write request, blocked while reset is held
  assign wr_req  = en && we && !rst;
  assign wr_word = wdata;

  assign cross_hit = peer_wr && (peer_addr == addr);

  generate
    if (SAME_MODE == RDW_NEW) begin : g_same_new
      assign same_word = wdata;
    end else if (SAME_MODE == RDW_OLD) begin : g_same_old
      assign same_word = stored;
    end else begin : g_same_dc
      assign same_word = '1;
    end

    if (CROSS_MODE == RDW_OLD) begin : g_cross_old
      assign cross_word = stored;
    end else begin : g_cross_dc
      assign cross_word = '1;
    end
  endgenerate

  always_comb begin
    if (we)             next_word = same_word;
    else if (cross_hit) next_word = cross_word;
    else                next_word = stored;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (en) rdata <= next_word;
  end
endmodule

// File: rtl/dpram_rdw.sv
module dpram_rdw
  import dpram_rdw_pkg::*;
#(
  parameter int         DATA_W     = 16,
  parameter int         ADDR_W     = 6,
  parameter logic [1:0] SAME_MODE  = RDW_DONTCARE,
  parameter logic [1:0] CROSS_MODE = RDW_DONTCARE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_a,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wdata_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic              en_b,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdata_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic              wr_a, wr_b;
  logic [DATA_W-1:0] wword_a, wword_b;
  logic [DATA_W-1:0] rword_a, rword_b;

  dpram_rdw_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .wr_a    (wr_a),
    .waddr_a (addr_a),
    .wword_a (wword_a),
    .wr_b    (wr_b),
    .waddr_b (addr_b),
    .wword_b (wword_b),
    .raddr_a (addr_a),
    .raddr_b (addr_b),
    .rword_a (rword_a),
    .rword_b (rword_b)
  );

  dpram_rdw_port #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .SAME_MODE(SAME_MODE), .CROSS_MODE(CROSS_MODE)
  ) u_port_a (
    .clk       (clk),
    .rst       (rst),
    .en        (en_a),
    .we        (we_a),
    .addr      (addr_a),
    .wdata     (wdata_a),
    .peer_wr   (wr_b),
    .peer_addr (addr_b),
    .stored    (rword_a),
    .wr_req    (wr_a),
    .wr_word   (wword_a),
    .rdata     (rdata_a)
  );

  dpram_rdw_port #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .SAME_MODE(SAME_MODE), .CROSS_MODE(CROSS_MODE)
  ) u_port_b (
    .clk       (clk),
    .rst       (rst),
    .en        (en_b),
    .we        (we_b),
    .addr      (addr_b),
    .wdata     (wdata_b),
    .peer_wr   (wr_a),
    .peer_addr (addr_a),
    .stored    (rword_b),
    .wr_req    (wr_b),
    .wr_word   (wword_b),
    .rdata     (rdata_b)
  );
endmodule

// File: rtl/dpram_rdw_chk.sv
module dpram_rdw_chk
  import dpram_rdw_pkg::*;
#(
  parameter int         DATA_W     = 16,
  parameter int         ADDR_W     = 6,
  parameter logic [1:0] SAME_MODE  = RDW_DONTCARE,
  parameter logic [1:0] CROSS_MODE = RDW_DONTCARE
) (
  input logic              clk,
  input logic              rst,
  input logic              en_a,
  input logic              we_a,
  input logic [ADDR_W-1:0] addr_a,
  input logic [DATA_W-1:0] wdata_a,
  input logic [DATA_W-1:0] rdata_a,
  input logic              en_b,
  input logic              we_b,
  input logic [ADDR_W-1:0] addr_b,
  input logic [DATA_W-1:0] wdata_b,
  input logic [DATA_W-1:0] rdata_b
);
  // R1: the edge after a reset edge shows zero on both outputs
  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdata_a == '0 && rdata_b == '0));

  // R3: a disabled port holds its output
  p_hold_a_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_a)) |-> $stable(rdata_a));
  p_hold_b_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_b)) |-> $stable(rdata_b));

  // R5: new-data mode returns the written word
  p_same_new_a_r5: assert property (@(posedge clk) disable iff (rst)
    ((SAME_MODE == RDW_NEW) && !$past(rst) && $past(en_a && we_a))
      |-> (rdata_a == $past(wdata_a)));
  p_same_new_b_r5: assert property (@(posedge clk) disable iff (rst)
    ((SAME_MODE == RDW_NEW) && !$past(rst) && $past(en_b && we_b))
      |-> (rdata_b == $past(wdata_b)));

  // R7: same-port don't care yields the all-ones fill
  p_same_dc_a_r7: assert property (@(posedge clk) disable iff (rst)
    ((SAME_MODE == RDW_DONTCARE) && !$past(rst) && $past(en_a && we_a))
      |-> (rdata_a == '1));
  p_same_dc_b_r7: assert property (@(posedge clk) disable iff (rst)
    ((SAME_MODE == RDW_DONTCARE) && !$past(rst) && $past(en_b && we_b))
      |-> (rdata_b == '1));

  // R9: cross-port don't care yields the all-ones fill on the reading port
  p_cross_dc_a_r9: assert property (@(posedge clk) disable iff (rst)
    ((CROSS_MODE == RDW_DONTCARE) && !$past(rst)
      && $past(en_a && !we_a && en_b && we_b && (addr_a == addr_b)))
      |-> (rdata_a == '1));
  p_cross_dc_b_r9: assert property (@(posedge clk) disable iff (rst)
    ((CROSS_MODE == RDW_DONTCARE) && !$past(rst)
      && $past(en_b && !we_b && en_a && we_a && (addr_a == addr_b)))
      |-> (rdata_b == '1));
endmodule

bind dpram_rdw dpram_rdw_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .SAME_MODE(SAME_MODE), .CROSS_MODE(CROSS_MODE)
) i_dpram_rdw_chk (
  .clk(clk), .rst(rst),
  .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
  .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b)
);

// File: tb/test_dpram_rdw.sv
module test_dpram_rdw;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_a = 0, we_a = 0, en_b = 0, we_b = 0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic [DW-1:0] wdata_a = '0, wdata_b = '0;
  logic [DW-1:0] ra [3];
  logic [DW-1:0] rb [3];

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // copy 0: new / old, copy 1: old / don't care, copy 2: defaults
  int same_m  [3] = '{0, 1, 2};
  int cross_m [3] = '{1, 2, 2};

  logic [DW-1:0] ref_mem [NW];
  logic [DW-1:0] exp_a [3];
  logic [DW-1:0] exp_b [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_rdw #(.DATA_W(DW), .ADDR_W(AW), .SAME_MODE(2'd0), .CROSS_MODE(2'd1)) i_dpram_rdw (
    .clk(clk), .rst(rst),
    .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(ra[0]),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rb[0]));

  dpram_rdw #(.DATA_W(DW), .ADDR_W(AW), .SAME_MODE(2'd1), .CROSS_MODE(2'd2)) i_dpram_rdw_old (
    .clk(clk), .rst(rst),
    .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(ra[1]),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rb[1]));

  // R11: default parameters
  dpram_rdw #(.DATA_W(DW), .ADDR_W(AW)) i_dpram_rdw_dflt (
    .clk(clk), .rst(rst),
    .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(ra[2]),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rb[2]));

  function automatic logic [DW-1:0] model_port(int d, logic we, logic [AW-1:0] a,
      logic [DW-1:0] wd, logic pw, logic [AW-1:0] pa);
    if (we) begin
      if (same_m[d] == 0) return wd;
      if (same_m[d] == 1) return ref_mem[a];
      return '1;
    end
    if (pw && pa == a) begin
      if (cross_m[d] == 1) return ref_mem[a];
      return '1;
    end
    return ref_mem[a];
  endfunction

  task automatic check(string tag, int d, string p, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s copy=%0d port=%s got=%h exp=%h", tag, d, p, got, exp);
    end
  endtask

  task automatic cyc(string tag, logic r, logic ea, logic wa, logic [AW-1:0] aa,
      logic [DW-1:0] da, logic eb, logic wb, logic [AW-1:0] ab, logic [DW-1:0] db);
    rst = r; en_a = ea; we_a = wa; addr_a = aa; wdata_a = da;
    en_b = eb; we_b = wb; addr_b = ab; wdata_b = db;
    for (int d = 0; d < 3; d++) begin
      if (r) begin
        exp_a[d] = '0; exp_b[d] = '0;
      end else begin
        if (ea) exp_a[d] = model_port(d, wa, aa, da, eb && wb, ab);
        if (eb) exp_b[d] = model_port(d, wb, ab, db, ea && wa, aa);
      end
    end
    if (!r) begin
      if (eb && wb) ref_mem[ab] = db;
      if (ea && wa) ref_mem[aa] = da;
    end
    @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      check(tag, d, "A", ra[d], exp_a[d]);
      check(tag, d, "B", rb[d], exp_b[d]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin exp_a[i] = '0; exp_b[i] = '0; end
    // R1: reset state
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4: fill the array, A on even words, B on odd
    for (int i = 0; i < NW; i += 2)
      cyc("R4", 0, 1, 1, AW'(i), DW'(16'h1000 + i), 1, 1, AW'(i+1), DW'(16'h2000 + i));
    // R2: read back from both ports
    for (int i = 0; i < NW; i++)
      cyc("R2", 0, 1, 0, AW'(i), 0, 1, 0, AW'(NW-1-i), 0);
    // R3: disabled write is ignored and outputs hold
    cyc("R3", 0, 0, 1, 6'd5, 16'hdead, 0, 1, 6'd9, 16'hbeef);
    cyc("R3", 0, 0, 0, 6'd0, 0, 0, 0, 6'd0, 0);
    cyc("R3", 0, 1, 0, 6'd5, 0, 1, 0, 6'd9, 0);
    // R5 R6 R7: same-port collisions, then read back
    cyc("R5_R6_R7", 0, 1, 1, 6'd3, 16'h3a3a, 0, 0, 0, 0);
    cyc("R5_R6_R7", 0, 0, 0, 0, 0, 1, 1, 6'd4, 16'h4b4b);
    cyc("R6", 0, 1, 0, 6'd3, 0, 1, 0, 6'd4, 0);
    // R8 R9: cross-port collisions in both directions
    cyc("R8_R9", 0, 1, 0, 6'd7, 0, 1, 1, 6'd7, 16'h7777);
    cyc("R8_R9", 0, 1, 1, 6'd8, 16'h8888, 1, 0, 6'd8, 0);
    cyc("R8", 0, 1, 0, 6'd7, 0, 1, 0, 6'd8, 0);
    // R10: both write one address, A wins
    cyc("R10", 0, 1, 1, 6'd12, 16'haaaa, 1, 1, 6'd12, 16'hbbbb);
    cyc("R10", 0, 0, 0, 0, 0, 1, 0, 6'd12, 0);
    // R1: reset blocks writes and keeps the array
    cyc("R1", 1, 1, 1, 6'd20, 16'h0bad, 1, 1, 6'd21, 16'h0bad);
    cyc("R1", 0, 1, 0, 6'd20, 0, 1, 0, 6'd21, 0);
    // mixed traffic on a narrow address range
    for (int i = 0; i < 600; i++)
      cyc("R2_mix", 0, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
          AW'($urandom_range(0, 7)), DW'($urandom),
          1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
          AW'($urandom_range(0, 7)), DW'($urandom));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule